// File: doc/BRIEF.md
# Critical-Word-First Cache Line Refill Controller

After a cache miss this block fetches one line of `WORDS` words from the next memory level. It issues one word request per cycle. In wrapped mode the first request is the word the CPU missed on, and the following requests continue upward and wrap past the end of the line. In sequential mode the requests start at word 0 and climb. In both modes the CPU is released on the beat that carries its word: `cpu_restart` pulses in that cycle with the data on `restart_data`. The remaining words continue to stream into the line after that beat.

Every returned beat is also presented on a write port toward the data array and kept in an internal line buffer. While the fill runs, the CPU may read words of the filling line. A word that has already landed is served from the buffer. A word that has not yet landed stalls the CPU until it does. The line is reported valid only once its last word is in. While a fill is running, further misses are not taken.

Top module: `lcf_fill_ctrl`

## Requirements
- R1: After reset `busy`, `line_valid`, `mem_req`, `cpu_restart`, `fill_we` and `cpu_stall` are all 0.
- R2: A `miss_req` sampled while idle is accepted. `busy` is 1 from the next cycle on, and `mem_req` is asserted in that same next cycle.
- R3: In wrapped mode (`wrap_mode`=1 at acceptance), request i (i = 0..WORDS-1) asks for word (crit + i) mod WORDS, where crit is the accepted `miss_word`. The first request is therefore the missed word.
- R4: In sequential mode (`wrap_mode`=0 at acceptance), request i asks for word i, whatever the missed word is.
- R5: A fill issues exactly WORDS requests, one per cycle on consecutive cycles. Every request carries the accepted line address on `mem_line`.
- R6: `cpu_restart` is 1 in exactly the cycle whose `mem_rvalid` beat carries the missed word, with `restart_data` equal to `mem_rdata`. It fires once per fill.
- R7: Each returned beat drives `fill_we`=1 in the same cycle, with `fill_word` equal to the word index of that beat in request order and `fill_data` equal to `mem_rdata`.
- R8: `line_valid` is 0 for the whole fill. It is 1 from the cycle after the last beat, which is also the first cycle with `busy`=0.
- R9: During a fill, `cpu_stall` equals `cpu_rd` AND the word at `cpu_word` has not yet been returned. A word counts as returned from the cycle after its beat. While idle, `cpu_stall` is 0.
- R10: When `cpu_rd` is 1 and `cpu_stall` is 0, `cpu_rdata` is the data returned for `cpu_word` during the latest fill.
- R11: A `miss_req` raised while `busy` is 1 is ignored. The running fill keeps its line and order, and no new fill starts once it ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_req | input | 1 | Miss to be refilled |
| miss_line | input | LINE_AW | Line address of the miss |
| miss_word | input | IDX_W | Word within the line that missed |
| wrap_mode | input | 1 | 1 = wrapped order, 0 = sequential order |
| busy | output | 1 | Fill in progress |
| line_valid | output | 1 | Last fill complete |
| mem_req | output | 1 | Word request to memory |
| mem_line | output | LINE_AW | Line address of the request |
| mem_word | output | IDX_W | Word index of the request |
| mem_rvalid | input | 1 | Returned word strobe (in request order) |
| mem_rdata | input | DATA_W | Returned word |
| fill_we | output | 1 | Write strobe to data array |
| fill_line | output | LINE_AW | Line being written |
| fill_word | output | IDX_W | Word being written |
| fill_data | output | DATA_W | Data being written |
| cpu_restart | output | 1 | Missed word has arrived; CPU may resume |
| restart_data | output | DATA_W | The missed word |
| cpu_rd | input | 1 | CPU reads a word of the filling line |
| cpu_word | input | IDX_W | Word the CPU reads |
| cpu_stall | output | 1 | Requested word not yet present |
| cpu_rdata | output | DATA_W | Read data |

## Verification
`busy` and the first memory request follow acceptance by one cycle. `cpu_restart`, `restart_data` and the array write port follow `mem_rvalid` in the same cycle. The presence of a word, and therefore the release of a stall, takes effect one cycle after its beat, and `line_valid` rises one cycle after the final beat. The bench drives inputs and samples every output at the falling edge, so each sample sees the settled result of the preceding rising edge. Its memory model returns words two cycles after their request and records which words have landed at the same rising edge the design uses. This makes the expected stall and read data in every cycle follow from the requirements alone.

// File: rtl/lcf_pkg.sv
package lcf_pkg;
   typedef enum logic [0:0] {
      FS_IDLE = 1'b0,
      FS_FILL = 1'b1
   } fill_state_e;
endpackage

// File: rtl/lcf_order.sv
module lcf_order #(
   parameter int WORDS   = 8,
   parameter int WRAP_EN = 1,
   parameter int IDX_W   = $clog2(WORDS)
) (
   input  logic             wrap,
   input  logic [IDX_W-1:0] crit,
   input  logic [IDX_W-1:0] beat,
   output logic [IDX_W-1:0] word
);
   generate
      if ((1 << IDX_W) != WORDS) begin : g_bad_words
         $error("lcf_order: WORDS must be a power of two");
      end
      if (WRAP_EN != 0) begin : g_wrap
         // Power-of-two line: modulo is plain truncation of the sum.
         assign word = wrap ? IDX_W'(crit + beat) : beat;
      end else begin : g_seq_only
         logic unused_wrap_in;
         assign unused_wrap_in = wrap ^ (^crit);
         assign word = beat;
      end
   endgenerate
endmodule

// File: rtl/lcf_line_buf.sv
module lcf_line_buf #(
   parameter int WORDS  = 8,
   parameter int DATA_W = 32,
   parameter int IDX_W  = $clog2(WORDS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [DATA_W-1:0] rd_data,
   output logic [WORDS-1:0]  present
);
   logic [DATA_W-1:0] word_q [WORDS];

   generate
      for (genvar g = 0; g < WORDS; g++) begin : g_word
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               word_q[g]  <= '0;
               present[g] <= 1'b0;
            end else if (clr) begin
               present[g] <= 1'b0;
            end else if (wr_en && (wr_idx == IDX_W'(g))) begin
               word_q[g]  <= wr_data;
               present[g] <= 1'b1;
            end
         end
      end
   endgenerate

   assign rd_data = word_q[rd_idx];

   // R7
   single_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && !clr |-> !present[wr_idx]);

   // R9
   one_word_per_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(clr) |-> $countones(present) <= $countones($past(present)) + 1);
endmodule

// File: rtl/lcf_fill_ctrl.sv
module lcf_fill_ctrl #(
   parameter int WORDS   = 8,
   parameter int DATA_W  = 32,
   parameter int LINE_AW = 10,
   parameter int WRAP_EN = 1,
   parameter int IDX_W   = $clog2(WORDS),
   parameter int CNT_W   = IDX_W + 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               miss_req,
   input  logic [LINE_AW-1:0] miss_line,
   input  logic [IDX_W-1:0]   miss_word,
   input  logic               wrap_mode,
   output logic               busy,
   output logic               line_valid,
   output logic               mem_req,
   output logic [LINE_AW-1:0] mem_line,
   output logic [IDX_W-1:0]   mem_word,
   input  logic               mem_rvalid,
   input  logic [DATA_W-1:0]  mem_rdata,
   output logic               fill_we,
   output logic [LINE_AW-1:0] fill_line,
   output logic [IDX_W-1:0]   fill_word,
   output logic [DATA_W-1:0]  fill_data,
   output logic               cpu_restart,
   output logic [DATA_W-1:0]  restart_data,
   input  logic               cpu_rd,
   input  logic [IDX_W-1:0]   cpu_word,
   output logic               cpu_stall,
   output logic [DATA_W-1:0]  cpu_rdata
);
   import lcf_pkg::*;

   localparam logic [CNT_W-1:0] LAST_BEAT = CNT_W'(WORDS - 1);
   localparam logic [CNT_W-1:0] ALL_BEATS = CNT_W'(WORDS);

   generate
      if (WORDS < 2) begin : g_bad_len
         $error("lcf_fill_ctrl: WORDS must be at least 2");
      end
      if (DATA_W < 1 || LINE_AW < 1) begin : g_bad_width
         $error("lcf_fill_ctrl: DATA_W and LINE_AW must be positive");
      end
   endgenerate

   fill_state_e          state_q;
   logic [LINE_AW-1:0]   line_q;
   logic [IDX_W-1:0]     crit_q;
   logic                 wrap_q;
   logic [CNT_W-1:0]     req_cnt_q;
   logic [CNT_W-1:0]     rx_cnt_q;
   logic                 valid_q;
   logic                 accept;
   logic                 beat_in;
   logic                 last_beat;
   logic [IDX_W-1:0]     req_word;
   logic [IDX_W-1:0]     rx_word;
   logic [WORDS-1:0]     present;
   logic [DATA_W-1:0]    buf_rdata;

   assign busy      = (state_q == FS_FILL);
   assign accept    = miss_req && !busy;
   assign beat_in   = busy && mem_rvalid;
   assign last_beat = beat_in && (rx_cnt_q == LAST_BEAT);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q   <= FS_IDLE;
         line_q    <= '0;
         crit_q    <= '0;
         wrap_q    <= 1'b0;
         req_cnt_q <= '0;
         rx_cnt_q  <= '0;
         valid_q   <= 1'b0;
      end else if (accept) begin
         state_q   <= FS_FILL;
         line_q    <= miss_line;
         crit_q    <= miss_word;
         wrap_q    <= wrap_mode;
         req_cnt_q <= '0;
         rx_cnt_q  <= '0;
         valid_q   <= 1'b0;
      end else if (busy) begin
         if (mem_req) begin
            req_cnt_q <= req_cnt_q + 1'b1;
         end
         if (beat_in) begin
            rx_cnt_q <= rx_cnt_q + 1'b1;
         end
         if (last_beat) begin
            state_q <= FS_IDLE;
            valid_q <= 1'b1;
         end
      end
   end

   lcf_order #(.WORDS(WORDS), .WRAP_EN(WRAP_EN), .IDX_W(IDX_W)) req_order_i (
      .wrap (wrap_q),
      .crit (crit_q),
      .beat (req_cnt_q[IDX_W-1:0]),
      .word (req_word)
   );

   lcf_order #(.WORDS(WORDS), .WRAP_EN(WRAP_EN), .IDX_W(IDX_W)) rx_order_i (
      .wrap (wrap_q),
      .crit (crit_q),
      .beat (rx_cnt_q[IDX_W-1:0]),
      .word (rx_word)
   );

   lcf_line_buf #(.WORDS(WORDS), .DATA_W(DATA_W), .IDX_W(IDX_W)) line_buf_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (accept),
      .wr_en   (beat_in),
      .wr_idx  (rx_word),
      .wr_data (mem_rdata),
      .rd_idx  (cpu_word),
      .rd_data (buf_rdata),
      .present (present)
   );

   assign mem_req      = busy && (req_cnt_q < ALL_BEATS);
   assign mem_line     = line_q;
   assign mem_word     = req_word;

   assign fill_we      = beat_in;
   assign fill_line    = line_q;
   assign fill_word    = rx_word;
   assign fill_data    = mem_rdata;

   assign cpu_restart  = beat_in && (rx_word == crit_q);
   assign restart_data = mem_rdata;

   assign cpu_stall    = cpu_rd && busy && !present[cpu_word];
   assign cpu_rdata    = buf_rdata;
   assign line_valid   = valid_q;

   // R3
   wrap_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(accept) && $past(wrap_mode) && (WRAP_EN != 0) |-> mem_req && mem_word == $past(miss_word));

   // R4
   seq_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(accept) && !$past(wrap_mode) |-> mem_req && mem_word == '0);

   // R11
   ignored_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy && miss_req |=> $stable(mem_line));

   // R8
   valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      line_valid |-> !busy);

   // R6
   single_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_restart |=> !cpu_restart);

   // R5
   req_in_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> mem_req);
endmodule

// File: tb/lcf_fill_ctrl_tb_top.sv
module lcf_fill_ctrl_tb_top;
   localparam int WORDS = 8;
   localparam int DW    = 32;
   localparam int LAW   = 10;
   localparam int IW    = 3;

   // {inject, wrap, crit[2:0], line[9:0], probe[2:0]}
   localparam logic [17:0] VEC [7] = '{
      {1'b1, 1'b1, 3'd5, 10'h012, 3'd7},
      {1'b0, 1'b1, 3'd0, 10'h3FF, 3'd0},
      {1'b0, 1'b1, 3'd7, 10'h155, 3'd6},
      {1'b1, 1'b0, 3'd5, 10'h0A0, 3'd3},
      {1'b0, 1'b0, 3'd0, 10'h201, 3'd7},
      {1'b0, 1'b0, 3'd7, 10'h077, 3'd1},
      {1'b0, 1'b1, 3'd3, 10'h100, 3'd2}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic miss_req = 1'b0;
   logic [LAW-1:0] miss_line = '0;
   logic [IW-1:0] miss_word = '0;
   logic wrap_mode = 1'b0;
   logic busy, line_valid, mem_req, fill_we, cpu_restart, cpu_stall;
   logic [LAW-1:0] mem_line, fill_line;
   logic [IW-1:0] mem_word, fill_word;
   logic [DW-1:0] fill_data, restart_data, cpu_rdata, mem_rdata;
   logic mem_rvalid;
   logic cpu_rd = 1'b0;
   logic [IW-1:0] cpu_word = '0;

   logic p0_v, p1_v;
   logic [IW-1:0] p0_w, p1_w;
   logic [LAW-1:0] p0_l, p1_l;
   logic [WORDS-1:0] recvd;

   int n_chk = 0, n_bad = 0;
   int req_i, restarts;
   bit mon_en = 1'b0;
   bit exp_wrap;
   logic [IW-1:0] exp_crit;
   logic [LAW-1:0] exp_line;

   always #5 clk = ~clk;

   lcf_fill_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .miss_req(miss_req), .miss_line(miss_line),
      .miss_word(miss_word), .wrap_mode(wrap_mode), .busy(busy),
      .line_valid(line_valid), .mem_req(mem_req), .mem_line(mem_line),
      .mem_word(mem_word), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
      .fill_we(fill_we), .fill_line(fill_line), .fill_word(fill_word),
      .fill_data(fill_data), .cpu_restart(cpu_restart),
      .restart_data(restart_data), .cpu_rd(cpu_rd), .cpu_word(cpu_word),
      .cpu_stall(cpu_stall), .cpu_rdata(cpu_rdata)
   );

   function automatic logic [DW-1:0] pat(input logic [LAW-1:0] l, input logic [IW-1:0] w);
      return {8'hA7, 6'd0, l, 5'd0, w};
   endfunction

   function automatic logic [IW-1:0] exp_order(input int i);
      return exp_wrap ? IW'(exp_crit + IW'(i)) : IW'(i);
   endfunction

   // memory model: in-order return, two cycles after the request
   always @(posedge clk) begin
      if (!rst_n) begin
         p0_v <= 1'b0; p1_v <= 1'b0;
         p0_w <= '0; p1_w <= '0; p0_l <= '0; p1_l <= '0;
         recvd <= '0;
      end else begin
         p0_v <= mem_req; p0_w <= mem_word; p0_l <= mem_line;
         p1_v <= p0_v;    p1_w <= p0_w;     p1_l <= p0_l;
         if (miss_req && !busy) recvd <= '0;
         else if (mem_rvalid) recvd[p1_w] <= 1'b1;
      end
   end
   assign mem_rvalid = p1_v;
   assign mem_rdata  = p1_v ? pat(p1_l, p1_w) : 32'hDEAD_BEEF;

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
      end
   endtask

   // cycle monitor, sampled away from the active edge
   always @(negedge clk) begin
      if (mon_en && rst_n) begin
         if (mem_req) begin
            chk(mem_line == exp_line, "R5 line", 32'(mem_line), 32'(exp_line));
            chk(mem_word == exp_order(req_i), exp_wrap ? "R3 order" : "R4 order",
                32'(mem_word), 32'(exp_order(req_i)));
            req_i++;
         end
         if (mem_rvalid) begin
            chk(fill_we && fill_word == p1_w && fill_data == pat(exp_line, p1_w) && fill_line == exp_line,
                "R7 fill port", {fill_we, 28'(fill_word)}, {1'b1, 28'(p1_w)});
            if (p1_w == exp_crit) begin
               chk(cpu_restart && restart_data == mem_rdata, "R6 restart", restart_data, mem_rdata);
               restarts++;
            end else begin
               chk(!cpu_restart, "R6 early restart", 32'(cpu_restart), 0);
            end
         end
         if (busy) begin
            chk(!line_valid, "R8 valid during fill", 32'(line_valid), 0);
            chk(cpu_stall == (cpu_rd && !recvd[cpu_word]), "R9 stall",
                32'(cpu_stall), 32'(cpu_rd && !recvd[cpu_word]));
            if (cpu_rd && !cpu_stall)
               chk(cpu_rdata == pat(exp_line, cpu_word), "R10 forward read",
                   cpu_rdata, pat(exp_line, cpu_word));
         end else begin
            chk(!cpu_stall, "R9 idle no stall", 32'(cpu_stall), 0);
         end
      end
   end

   task automatic run_fill(input logic [17:0] v);
      int waited;
      @(negedge clk);
      exp_wrap = v[16];
      exp_crit = v[15:13];
      exp_line = v[12:3];
      req_i = 0;
      restarts = 0;
      miss_req = 1'b1; wrap_mode = v[16]; miss_word = v[15:13]; miss_line = v[12:3];
      cpu_rd = 1'b1; cpu_word = v[2:0];
      mon_en = 1'b1;
      @(negedge clk);
      miss_req = 1'b0;
      chk(busy && mem_req, "R2 accept", {busy, mem_req}, 2'b11);
      waited = 0;
      while (busy && waited < 40) begin
         if (v[17] && waited == 2) begin
            miss_req = 1'b1; miss_line = ~v[12:3]; miss_word = ~v[15:13]; wrap_mode = ~v[16];
         end else begin
            miss_req = 1'b0;
         end
         @(negedge clk);
         waited++;
      end
      miss_req = 1'b0;
      chk(!busy, "R8 fill ends", 32'(busy), 0);
      chk(line_valid, "R8 valid after last", 32'(line_valid), 1);
      chk(req_i == WORDS, "R5 beat count", req_i, WORDS);
      chk(restarts == 1, "R6 once", restarts, 1);
      if (v[17]) begin
         repeat (3) begin
            @(negedge clk);
            chk(!busy && !mem_req, "R11 no refill", {busy, mem_req}, 0);
         end
      end
      for (int w = 0; w < WORDS; w++) begin
         cpu_word = IW'(w);
         #1;
         chk(!cpu_stall && cpu_rdata == pat(exp_line, IW'(w)), "R10 line read",
             cpu_rdata, pat(exp_line, IW'(w)));
      end
      cpu_rd = 1'b0;
      mon_en = 1'b0;
   endtask

   task automatic finish_run();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(!busy && !line_valid && !mem_req && !cpu_restart && !fill_we && !cpu_stall,
          "R1 reset", {busy, line_valid, mem_req, cpu_restart, fill_we, cpu_stall}, 0);
      // R9 idle read never stalls
      cpu_rd = 1'b1; cpu_word = 3'd4;
      #1;
      chk(!cpu_stall, "R9 idle read", 32'(cpu_stall), 0);
      cpu_rd = 1'b0;

      for (int i = 0; i < 7; i++) run_fill(VEC[i]);

      // back-to-back misses: second accepted the cycle after the first ends
      run_fill({1'b0, 1'b1, 3'd6, 10'h2AA, 3'd5});
      run_fill({1'b0, 1'b0, 3'd2, 10'h2AB, 3'd2});

      // reset in the middle of a fill clears everything (R1)
      @(negedge clk);
      miss_req = 1'b1; miss_line = 10'h033; miss_word = 3'd1; wrap_mode = 1'b1;
      @(negedge clk);
      miss_req = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      chk(!busy && !line_valid && !mem_req && !fill_we, "R1 mid-fill reset",
          {busy, line_valid, mem_req, fill_we}, 0);
      repeat (4) @(negedge clk);
      chk(!busy && !mem_req, "R1 stays idle", {busy, mem_req}, 0);

      finish_run();
   end
endmodule